// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a processor's load path and a slower backing store that is addressed in words. Each request carries a 32-bit byte address. The address is cut into four fields: the byte position inside a word, the word position inside a line, the line number, and a tag made of every bit above the line number. The line number selects exactly one line. That line's stored tag and valid flag decide whether the request is a hit.

On a hit the selected word comes back on the cycle after the request is taken. On a miss the controller reads every word of the aligned line from the backing store in ascending order, one request at a time. It writes those words and the new tag into the chosen line, then answers the processor from the freshly filled line. Any addresses that share a line number compete for that single line, so each fill replaces whatever the line held before. The defaults are 64 lines of four 32-bit words.

Top module: `dmc_top`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, `cpu_rvalid` is 0 and `mem_req` is 0, so the first access to any line is a miss.
- R2: Address bits [1:0] select a byte and have no effect on the result. Bits [3:2] select the word within a line. The line number is floor(word address / words per line) mod the number of lines, and the tag is every bit above the line number.
- R3: A request is a hit when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_rvalid` with the selected word on the cycle after acceptance and issues no memory request.
- R4: A miss reads the words of the aligned line in ascending order. `mem_addr` is a word address (byte address shifted right by 2), and the first word has its low 2 bits cleared.
- R5: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen. `mem_rvalid` is taken only while `mem_req` is high.
- R6: `cpu_ready` stays low from the cycle a miss is detected until the requested word is returned. The returned word equals the word fetched from memory.
- R7: A fill replaces the previous contents of its line, so the tag that was evicted misses on its next access.
- R8: `cpu_ready` is high in every cycle that `cpu_rvalid` is high, so back-to-back requests are accepted without a gap.
- R9: Each miss performs exactly as many memory transfers as there are words per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | 32 | Processor byte address |
| cpu_ready | output | 1 | Request is accepted when this and `cpu_req` are both high |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Read data word |
| mem_req | output | 1 | Backing-store word request |
| mem_addr | output | 30 | Backing-store word address |
| mem_rvalid | input | 1 | Backing-store data valid for the current request |
| mem_rdata | input | 32 | Backing-store data word |

## Verification
The checker assumes the backing store raises `mem_rvalid` only while `mem_req` is high, and only for a single cycle per word. It also assumes that `cpu_req` is dropped once the request has been taken. The bench memory model responds solely to a pending request, after a chosen wait of zero to three cycles, and lowers its valid flag on the next cycle. The processor side raises `cpu_req` for exactly one accepted cycle. A small eight-line configuration lets the sweeps reach every line, every word position, every byte offset and repeated tag conflicts.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_FILL   = 2'd2
   } dmc_state_e;

   // number of address bits needed to select one of n items (0 when n <= 1)
   function automatic int unsigned field_bits(input int unsigned n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction

   // a vector width that never collapses to zero
   function automatic int unsigned min_one(input int unsigned n);
      return (n == 0) ? 1 : n;
   endfunction

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int unsigned WADDR_W  = 30,
   parameter int unsigned OFF_BITS = 2,
   parameter int unsigned OFF_W    = 2,
   parameter int unsigned IDX_BITS = 6,
   parameter int unsigned TAG_BITS = 22
) (
   input  logic [WADDR_W-1:0]  word_addr,
   output logic [TAG_BITS-1:0] tag,
   output logic [IDX_BITS-1:0] idx,
   output logic [OFF_W-1:0]    off
);

   assign tag = word_addr[WADDR_W-1 -: TAG_BITS];
   assign idx = word_addr[OFF_BITS +: IDX_BITS];

   generate
      if (OFF_BITS == 0) begin : g_single_word
         assign off = '0;
      end else begin : g_multi_word
         assign off = word_addr[OFF_BITS-1:0];
      end
   endgenerate

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int unsigned LINES    = 64,
   parameter int unsigned IDX_BITS = 6,
   parameter int unsigned TAG_BITS = 22
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_BITS-1:0] lk_idx,
   input  logic [TAG_BITS-1:0] lk_tag,
   output logic                lk_hit,
   input  logic                wr_en,
   input  logic [IDX_BITS-1:0] wr_idx,
   input  logic [TAG_BITS-1:0] wr_tag
);

   logic [LINES-1:0]    valid_q;
   logic [TAG_BITS-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int unsigned LINES    = 64,
   parameter int unsigned WPL      = 4,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned IDX_BITS = 6,
   parameter int unsigned OFF_BITS = 2,
   parameter int unsigned OFF_W    = 2
) (
   input  logic                clk,
   input  logic [IDX_BITS-1:0] rd_idx,
   input  logic [OFF_W-1:0]    rd_off,
   output logic [WORD_W-1:0]   rd_data,
   input  logic                wr_en,
   input  logic [IDX_BITS-1:0] wr_idx,
   input  logic [OFF_W-1:0]    wr_off,
   input  logic [WORD_W-1:0]   wr_data
);

   localparam int unsigned DEPTH  = LINES * WPL;
   localparam int unsigned SLOT_W = IDX_BITS + OFF_BITS;

   logic [WORD_W-1:0] words_q [DEPTH];
   logic [SLOT_W-1:0] rd_slot;
   logic [SLOT_W-1:0] wr_slot;

   generate
      if (OFF_BITS == 0) begin : g_line_is_word
         logic unused_offsets;
         assign unused_offsets = ^{rd_off, wr_off};
         assign rd_slot = rd_idx;
         assign wr_slot = wr_idx;
      end else begin : g_line_has_words
         assign rd_slot = {rd_idx, rd_off[OFF_BITS-1:0]};
         assign wr_slot = {wr_idx, wr_off[OFF_BITS-1:0]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) begin
         words_q[wr_slot] <= wr_data;
      end
   end

   assign rd_data = words_q[rd_slot];

endmodule

// File: rtl/dmc_refill_fsm.sv
module dmc_refill_fsm
   import dmc_pkg::*;
#(
   parameter int unsigned WPL   = 4,
   parameter int unsigned OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             lk_hit,
   input  logic             mem_rvalid,
   output logic             cpu_ready,
   output logic             cpu_rvalid,
   output logic             accept,
   output logic             mem_req,
   output logic [OFF_W-1:0] beat,
   output logic             data_we,
   output logic             tag_we
);

   dmc_state_e       state_q, state_d;
   logic [OFF_W-1:0] beat_q;
   logic             in_lookup;
   logic             beat_done;
   logic             last_beat;

   assign in_lookup  = (state_q == ST_LOOKUP);
   assign cpu_rvalid = in_lookup && lk_hit;
   assign cpu_ready  = (state_q == ST_IDLE) || cpu_rvalid;
   assign accept     = cpu_req && cpu_ready;
   assign mem_req    = (state_q == ST_FILL);
   assign beat_done  = mem_req && mem_rvalid;

   generate
      if (WPL == 1) begin : g_one_beat
         assign last_beat = 1'b1;
      end else begin : g_many_beats
         assign last_beat = (beat_q == OFF_W'(WPL - 1));
      end
   endgenerate

   assign beat    = beat_q;
   assign data_we = beat_done;
   assign tag_we  = beat_done && last_beat;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) state_d = ST_LOOKUP;
         end
         ST_LOOKUP: begin
            if (!lk_hit)     state_d = ST_FILL;
            else if (accept) state_d = ST_LOOKUP;
            else             state_d = ST_IDLE;
         end
         ST_FILL: begin
            if (beat_done && last_beat) state_d = ST_LOOKUP;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         if (!mem_req)       beat_q <= '0;
         else if (beat_done) beat_q <= beat_q + 1'b1;
      end
   end

endmodule

// File: rtl/dmc_top.sv
module dmc_top
   import dmc_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned LINES          = 64,
   parameter int unsigned WORDS_PER_LINE = 4,
   localparam int unsigned BYTE_BITS     = $clog2(WORD_W / 8),
   localparam int unsigned MA_W          = ADDR_W - BYTE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              cpu_rvalid,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic [MA_W-1:0]   mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata
);

   localparam int unsigned OFF_BITS = field_bits(WORDS_PER_LINE);
   localparam int unsigned OFF_W    = min_one(OFF_BITS);
   localparam int unsigned IDX_BITS = $clog2(LINES);
   localparam int unsigned TAG_BITS = MA_W - OFF_BITS - IDX_BITS;

   generate
      if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 8");
      end
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (WORDS_PER_LINE < 1 || (WORDS_PER_LINE & (WORDS_PER_LINE - 1)) != 0) begin : g_bad_wpl
         $error("WORDS_PER_LINE must be a power of two");
      end
      if (ADDR_W <= BYTE_BITS + OFF_BITS + IDX_BITS) begin : g_bad_addr
         $error("ADDR_W leaves no tag bits");
      end
   endgenerate

   // byte position inside a word never affects a read
   logic unused_byte_bits;
   assign unused_byte_bits = ^cpu_addr[BYTE_BITS-1:0];

   logic [MA_W-1:0]     waddr_q;
   logic [TAG_BITS-1:0] a_tag;
   logic [IDX_BITS-1:0] a_idx;
   logic [OFF_W-1:0]    a_off;
   logic                lk_hit;
   logic                accept;
   logic [OFF_W-1:0]    beat;
   logic                data_we;
   logic                tag_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr_q <= '0;
      end else if (accept) begin
         waddr_q <= cpu_addr[ADDR_W-1:BYTE_BITS];
      end
   end

   dmc_addr_split #(
      .WADDR_W (MA_W),
      .OFF_BITS(OFF_BITS),
      .OFF_W   (OFF_W),
      .IDX_BITS(IDX_BITS),
      .TAG_BITS(TAG_BITS)
   ) u_split (
      .word_addr(waddr_q),
      .tag      (a_tag),
      .idx      (a_idx),
      .off      (a_off)
   );

   dmc_tag_store #(
      .LINES   (LINES),
      .IDX_BITS(IDX_BITS),
      .TAG_BITS(TAG_BITS)
   ) u_tags (
      .clk   (clk),
      .rst_n (rst_n),
      .lk_idx(a_idx),
      .lk_tag(a_tag),
      .lk_hit(lk_hit),
      .wr_en (tag_we),
      .wr_idx(a_idx),
      .wr_tag(a_tag)
   );

   dmc_data_store #(
      .LINES   (LINES),
      .WPL     (WORDS_PER_LINE),
      .WORD_W  (WORD_W),
      .IDX_BITS(IDX_BITS),
      .OFF_BITS(OFF_BITS),
      .OFF_W   (OFF_W)
   ) u_data (
      .clk    (clk),
      .rd_idx (a_idx),
      .rd_off (a_off),
      .rd_data(cpu_rdata),
      .wr_en  (data_we),
      .wr_idx (a_idx),
      .wr_off (beat),
      .wr_data(mem_rdata)
   );

   dmc_refill_fsm #(
      .WPL  (WORDS_PER_LINE),
      .OFF_W(OFF_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .lk_hit    (lk_hit),
      .mem_rvalid(mem_rvalid),
      .cpu_ready (cpu_ready),
      .cpu_rvalid(cpu_rvalid),
      .accept    (accept),
      .mem_req   (mem_req),
      .beat      (beat),
      .data_we   (data_we),
      .tag_we    (tag_we)
   );

   generate
      if (OFF_BITS == 0) begin : g_addr_line
         assign mem_addr = {a_tag, a_idx};
      end else begin : g_addr_beat
         assign mem_addr = {a_tag, a_idx, beat[OFF_BITS-1:0]};
      end
   endgenerate

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int unsigned WPL  = 4,
   parameter int unsigned MA_W = 30
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_ready,
   input logic            cpu_rvalid,
   input logic            mem_req,
   input logic [MA_W-1:0] mem_addr,
   input logic            mem_rvalid
);

   localparam int unsigned CNT_W = $clog2(WPL + 1);

   logic [CNT_W-1:0] beats_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          beats_q <= '0;
      else if (!mem_req)   beats_q <= '0;
      else if (mem_rvalid) beats_q <= beats_q + 1'b1;
   end

   // R1: out of reset the block is idle and ready
   always @(posedge clk) begin
      if (rst_n && !$past(rst_n)) begin
         a_reset_idle_r1: assert (cpu_ready && !cpu_rvalid && !mem_req)
            else $error("R1: not idle after reset");
      end
   end

   p_no_resp_in_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> !mem_req);

   p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (mem_addr % WPL) == 0);

   p_fill_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1));

   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   p_busy_in_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   p_ready_with_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> cpu_ready);

   p_beat_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> beats_q == CNT_W'(WPL));

endmodule

bind dmc_top dmc_checker #(
   .WPL (WORDS_PER_LINE),
   .MA_W(MA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .cpu_rvalid(cpu_rvalid),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_rvalid(mem_rvalid)
);

// File: tb/dmc_top_tb.sv
module dmc_top_tb;

   localparam int unsigned LINES = 8;
   localparam int unsigned WPL   = 4;
   localparam int unsigned MA_W  = 30;
   localparam int unsigned LINE_BYTES = WPL * 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic            cpu_req = 1'b0;
   logic [31:0]     cpu_addr = '0;
   logic            cpu_ready;
   logic            cpu_rvalid;
   logic [31:0]     cpu_rdata;
   logic            mem_req;
   logic [MA_W-1:0] mem_addr;
   logic            mem_rvalid = 1'b0;
   logic [31:0]     mem_rdata = '0;

   dmc_top #(
      .ADDR_W        (32),
      .WORD_W        (32),
      .LINES         (LINES),
      .WORDS_PER_LINE(WPL)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_addr  (cpu_addr),
      .cpu_ready (cpu_ready),
      .cpu_rvalid(cpu_rvalid),
      .cpu_rdata (cpu_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_rvalid(mem_rvalid),
      .mem_rdata (mem_rdata)
   );

   int n_vec = 0;
   int n_bad = 0;
   int lat = 0;
   int wcnt = 0;
   int nbeats = 0;
   bit finished = 1'b0;
   bit obs_hit;
   logic [MA_W-1:0] held_addr;
   logic [MA_W-1:0] beat_addr [8];
   bit              mv [LINES];
   logic [31:0]     mt [LINES];

   function automatic logic [31:0] fval(input logic [MA_W-1:0] w);
      return ({2'b00, w} * 32'h9E3779B1) ^ 32'hC0FFEE00;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // backing store: answers a pending word request after lat idle cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rvalid = 1'b0;
         wcnt = 0;
      end else if (mem_rvalid) begin
         mem_rvalid = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt > 0) begin
            chk(mem_addr == held_addr, "R5 address held while waiting", 32'(mem_addr), 32'(held_addr));
         end
         held_addr = mem_addr;
         if (wcnt >= lat) begin
            mem_rvalid = 1'b1;
            mem_rdata  = fval(mem_addr);
            if (nbeats < 8) beat_addr[nbeats] = mem_addr;
            nbeats++;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic access(input logic [31:0] a);
      logic [MA_W-1:0] w;
      logic [MA_W-1:0] base;
      int unsigned     li;
      logic [31:0]     t;
      bit              exp_hit;
      bit              ready_bad;
      int              cyc;
      w       = a[31:2];
      base    = w & ~MA_W'(WPL - 1);
      li      = (32'(w) / WPL) % LINES;
      t       = 32'(w) / (WPL * LINES);
      exp_hit = mv[li] && (mt[li] == t);
      while (!cpu_ready) @(negedge clk);
      nbeats   = 0;
      cpu_req  = 1'b1;
      cpu_addr = a;
      @(negedge clk);
      cpu_req   = 1'b0;
      cyc       = 1;
      ready_bad = 1'b0;
      while (!cpu_rvalid && cyc < 500) begin
         if (cpu_ready) ready_bad = 1'b1;
         @(negedge clk);
         cyc++;
      end
      obs_hit = (cyc == 1) && (nbeats == 0);
      chk(cpu_rvalid, "R6 response arrived", 32'(cpu_rvalid), 32'd1);
      chk(cpu_rdata == fval(w), exp_hit ? "R3 hit data" : "R6 refill data", cpu_rdata, fval(w));
      chk(cpu_ready, "R8 ready alongside response", 32'(cpu_ready), 32'd1);
      if (exp_hit) begin
         chk(cyc == 1, "R3 hit latency", 32'(cyc), 32'd1);
         chk(nbeats == 0, "R3 no memory traffic on hit", 32'(nbeats), 32'd0);
      end else begin
         chk(nbeats == WPL, "R9 transfers per miss", 32'(nbeats), 32'(WPL));
         for (int k = 0; k < WPL && k < nbeats; k++) begin
            chk(beat_addr[k] == base + MA_W'(k), "R4 fill order", 32'(beat_addr[k]), 32'(base + MA_W'(k)));
         end
         chk(!ready_bad, "R6 ready held low during miss", 32'(ready_bad), 32'd0);
      end
      mv[li] = 1'b1;
      mt[li] = t;
   endtask

   initial begin
      logic [31:0] lfsr;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_ready == 1'b1, "R1 ready after reset", 32'(cpu_ready), 32'd1);
      chk(cpu_rvalid == 1'b0, "R1 no response after reset", 32'(cpu_rvalid), 32'd0);
      chk(mem_req == 1'b0, "R1 no memory request after reset", 32'(mem_req), 32'd0);

      // every line, every word, varied byte offsets and wait states
      for (int ln = 0; ln < LINES; ln++) begin
         for (int wd = 0; wd < WPL; wd++) begin
            lat = ln % 4;
            access(32'(ln * LINE_BYTES + wd * 4 + (wd % 4)));
            if (wd == 0) chk(!obs_hit, "R1 cold line misses", 32'(obs_hit), 32'd0);
            else         chk(obs_hit, "R2 same line word hits", 32'(obs_hit), 32'd1);
         end
      end

      // byte position inside the word has no effect
      for (int b = 0; b < 4; b++) begin
         access(32'h24 + 32'(b));
         chk(obs_hit, "R2 byte offset ignored", 32'(obs_hit), 32'd1);
      end

      // conflicting tags on one line
      lat = 1;
      access(32'h1030);
      chk(!obs_hit, "R7 new tag on occupied line misses", 32'(obs_hit), 32'd0);
      access(32'h0034);
      chk(!obs_hit, "R7 evicted tag misses again", 32'(obs_hit), 32'd0);
      access(32'h0038);
      chk(obs_hit, "R7 refilled line hits", 32'(obs_hit), 32'd1);
      access(32'h8000_0030);
      chk(!obs_hit, "R2 top tag bit distinguishes lines", 32'(obs_hit), 32'd0);
      access(32'h1034);
      chk(!obs_hit, "R7 earlier tag was evicted", 32'(obs_hit), 32'd0);

      // pseudo-random sweep over four tags plus the top address bit
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lat  = int'(lfsr[5:4]);
         access({lfsr[20], 22'd0, lfsr[8:0]});
      end

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule